// File: doc/BRIEF.md
# Token-Tagged Cache Line Detector

This block is a small direct-mapped, write-back data cache that also catches accesses to memory poisoned with a secret 512-bit token. Software places the token value in every 64-byte line it wants to guard, either by writing the pattern into memory or by arming a cache line directly. Each cache line carries one extra bit that records whether the line holds the token. The full 512-bit compare against the token register is made only when a line is filled from memory. Hits rely on the stored bit alone.

An ordinary load or store that reaches a tagged line is blocked and reported. The store leaves the line untouched. The load returns zero. The response carries a one-cycle violation flag. Only a disarm can remove the tag. When an armed line that has been modified is evicted, the block writes the token pattern itself back to memory, so the token never has to be held as line data.

The core port accepts one request at a time through a ready/valid handshake and answers with a single-cycle response. The memory port moves whole lines and completes each transfer on an acknowledge. The token register can be loaded while the controller is idle, and loading it empties the cache.

Top module: `token_line_cache`

## Requirements
- R1: During and right after reset, reqReady is 1, rspValid is 0 and memValid is 0.
- R2: A load that misses issues one memory read of the 64-byte-aligned line address. It answers with the 64-bit word selected by address bits [5:3] of the fetched line (reqOp encoding: 0 load, 1 store, 2 arm, 3 disarm).
- R3: When a fill returns data equal in all 512 bits to the token register, the line is tagged, and a later load or store to it violates.
- R4: On a hit to an untagged line, a store replaces only the addressed 64-bit word and marks the line dirty. A later load returns the stored word with no violation.
- R5: An arm to a 64-byte-aligned address tags the line, fetching it first on a miss. Later loads to any word of it violate.
- R6: A store to a tagged line raises a violation and does not change the line contents.
- R7: A disarm to an aligned address clears the tag. If the line was tagged, its data becomes all zero. If the line was untagged, the disarm leaves its data unchanged.
- R8: Evicting a dirty tagged line writes the token register value to memory. Evicting a dirty untagged line writes its data. Evicting a clean line writes nothing.
- R9: An arm or disarm whose address bits [5:0] are not zero is answered with rspError = 1 and leaves the tag and data unchanged.
- R10: A violation is reported as rspViolation = 1 for exactly one cycle, together with rspValid, and with rspData = 0.
- R11: A token write is taken only while the controller is idle and has priority over a request offered in the same cycle. reqReady is 0 in that cycle. All lines are invalidated, and their dirty data is dropped without write-back.
- R12: Only one request is in flight. reqReady stays 0 while a memory transfer is pending, and memValid, memWrite and memAddr hold steady until memAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core request offered |
| reqReady | output | 1 | Core request accepted this cycle |
| reqOp | input | 2 | 0 load, 1 store, 2 arm, 3 disarm |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | WORD_W | Store data |
| rspValid | output | 1 | Response strobe, one cycle |
| rspData | output | WORD_W | Load data, zero otherwise |
| rspViolation | output | 1 | Access touched a tagged line |
| rspError | output | 1 | Misaligned arm or disarm |
| tokWe | input | 1 | Load token register |
| tokData | input | LINE_BYTES*8 | New token value |
| memValid | output | 1 | Memory transfer pending |
| memWrite | output | 1 | Transfer is a write-back |
| memAddr | output | ADDR_W | Line-aligned memory address |
| memWdata | output | LINE_BYTES*8 | Write-back line |
| memAck | input | 1 | Transfer done, read data valid |
| memRdata | input | LINE_BYTES*8 | Fill line |

## Verification
A token register write and a core request can be offered in the same idle cycle, and the block must settle which one goes first. The bench provokes this by raising tokWe and reqValid together for a load to a line that holds dirty data. It first judges that reqReady is low in that cycle. It then judges the outcome at the memory port: the load that follows must cause a fresh read and no write-back, and it must return memory's old word. A second load, to a line that matched the old token, must now come back untagged under the new token.

// File: rtl/token_line_cache_pkg.sv
package token_line_cache_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ARM    = 2'd2,
    OP_DISARM = 2'd3
  } opKind_t;

  // Strobes from the controller to the datapath, one cycle each
  typedef struct packed {
    logic latchReq;    // capture the accepted core request
    logic loadToken;   // take a new token and empty the cache
    logic fillLine;    // install memRdata in the indexed line
    logic commitOp;    // apply the latched op to a hit line
    logic respond;     // produce the core response
    logic respondErr;  // response is a misalignment error
  } ctlStrobes_t;

endpackage

// File: rtl/token_line_cache_ctrl.sv
module token_line_cache_ctrl
  import token_line_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        tokWe,
  input  logic        hit,
  input  logic        victimDirty,
  input  logic        misaligned,
  input  logic        isTagOp,
  input  logic        memAck,
  output logic        reqReady,
  output logic        memValid,
  output logic        memWrite,
  output ctlStrobes_t strobes
);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WRITEBACK, S_FILL} state_t;

  state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    reqReady  = 1'b0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    case (state)
      S_IDLE: begin
        // a token write wins over a request offered in the same cycle
        reqReady = !tokWe;
        if (tokWe) begin
          strobes.loadToken = 1'b1;
        end else if (reqValid) begin
          strobes.latchReq = 1'b1;
          nextState        = S_CHECK;
        end
      end
      S_CHECK: begin
        if (isTagOp && misaligned) begin
          strobes.respond    = 1'b1;
          strobes.respondErr = 1'b1;
          nextState          = S_IDLE;
        end else if (hit) begin
          strobes.commitOp = 1'b1;
          strobes.respond  = 1'b1;
          nextState        = S_IDLE;
        end else if (victimDirty) begin
          nextState = S_WRITEBACK;
        end else begin
          nextState = S_FILL;
        end
      end
      S_WRITEBACK: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memAck) nextState = S_FILL;
      end
      S_FILL: begin
        memValid = 1'b1;
        if (memAck) begin
          strobes.fillLine = 1'b1;
          nextState        = S_CHECK;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/token_line_cache_dp.sv
module token_line_cache_dp
  import token_line_cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [1:0]            reqOp,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [WORD_W-1:0]     reqWdata,
  input  logic [LINE_BYTES*8-1:0] tokData,
  input  logic [LINE_BYTES*8-1:0] memRdata,
  output logic                  hit,
  output logic                  victimDirty,
  output logic                  misaligned,
  output logic                  isTagOp,
  output logic [ADDR_W-1:0]     victimLineAddr,
  output logic [ADDR_W-1:0]     reqLineAddr,
  output logic [LINE_BYTES*8-1:0] wbData,
  output logic                  rspValid,
  output logic [WORD_W-1:0]     rspData,
  output logic                  rspViolation,
  output logic                  rspError
);

  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WPL    = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int BSEL_W = $clog2(WORD_W / 8);

  opKind_t             curOp;
  logic [ADDR_W-1:0]   curAddr;
  logic [WORD_W-1:0]   curWdata;
  logic [LINE_W-1:0]   tokenReg;

  logic [LINES-1:0]    lineValid, lineDirty, lineToken;
  logic [TAG_W-1:0]    lineTag  [LINES];
  logic [LINE_W-1:0]   lineData [LINES];

  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    curTag;
  logic [WSEL_W-1:0]   wsel;
  logic [LINE_W-1:0]   curLine, mergedLine;
  logic [WORD_W-1:0]   curWords [WPL];
  logic                lineIsToken, accessOp;

  assign idx     = curAddr[OFF_W +: IDX_W];
  assign curTag  = curAddr[ADDR_W-1 -: TAG_W];
  assign wsel    = curAddr[BSEL_W +: WSEL_W];
  assign curLine = lineData[idx];

  // word view of the indexed line and the store merge
  for (genvar w = 0; w < WPL; w++) begin : g_word
    assign curWords[w] = curLine[w*WORD_W +: WORD_W];
    assign mergedLine[w*WORD_W +: WORD_W] =
      (wsel == WSEL_W'(w)) ? curWdata : curLine[w*WORD_W +: WORD_W];
  end

  assign lineIsToken    = lineToken[idx];
  assign accessOp       = (curOp == OP_LOAD) || (curOp == OP_STORE);
  assign isTagOp        = (curOp == OP_ARM) || (curOp == OP_DISARM);
  assign misaligned     = curAddr[OFF_W-1:0] != '0;
  assign hit            = lineValid[idx] && (lineTag[idx] == curTag);
  assign victimDirty    = lineValid[idx] && lineDirty[idx];
  assign victimLineAddr = {lineTag[idx], idx, {OFF_W{1'b0}}};
  assign reqLineAddr    = {curTag, idx, {OFF_W{1'b0}}};
  // a tagged line is written back as the token itself
  assign wbData         = lineIsToken ? tokenReg : curLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOp        <= OP_LOAD;
      curAddr      <= '0;
      curWdata     <= '0;
      tokenReg     <= '0;
      lineValid    <= '0;
      lineDirty    <= '0;
      lineToken    <= '0;
      rspValid     <= 1'b0;
      rspData      <= '0;
      rspViolation <= 1'b0;
      rspError     <= 1'b0;
    end else begin
      if (strobes.latchReq) begin
        curOp    <= opKind_t'(reqOp);
        curAddr  <= reqAddr;
        curWdata <= reqWdata;
      end
      if (strobes.loadToken) begin
        tokenReg  <= tokData;
        lineValid <= '0;
      end
      if (strobes.fillLine) begin
        lineValid[idx] <= 1'b1;
        lineDirty[idx] <= 1'b0;
        lineToken[idx] <= (memRdata == tokenReg);
      end
      if (strobes.commitOp) begin
        case (curOp)
          OP_STORE:  if (!lineIsToken) lineDirty[idx] <= 1'b1;
          OP_ARM: begin
            lineToken[idx] <= 1'b1;
            lineDirty[idx] <= 1'b1;
          end
          OP_DISARM: if (lineIsToken) begin
            lineToken[idx] <= 1'b0;
            lineDirty[idx] <= 1'b1;
          end
          default: ;
        endcase
      end
      rspValid     <= strobes.respond;
      rspError     <= strobes.respond && strobes.respondErr;
      rspViolation <= strobes.respond && !strobes.respondErr && accessOp && lineIsToken;
      rspData      <= (strobes.respond && !strobes.respondErr && curOp == OP_LOAD && !lineIsToken)
                      ? curWords[wsel] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fillLine) begin
      lineData[idx] <= memRdata;
      lineTag[idx]  <= curTag;
    end else if (strobes.commitOp) begin
      if (curOp == OP_STORE && !lineIsToken)       lineData[idx] <= mergedLine;
      else if (curOp == OP_DISARM && lineIsToken)  lineData[idx] <= '0;
    end
  end

endmodule

// File: rtl/token_line_cache.sv
module token_line_cache
  import token_line_cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [1:0]              reqOp,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [WORD_W-1:0]       reqWdata,
  output logic                    rspValid,
  output logic [WORD_W-1:0]       rspData,
  output logic                    rspViolation,
  output logic                    rspError,
  input  logic                    tokWe,
  input  logic [LINE_BYTES*8-1:0] tokData,
  output logic                    memValid,
  output logic                    memWrite,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LINE_BYTES*8-1:0] memWdata,
  input  logic                    memAck,
  input  logic [LINE_BYTES*8-1:0] memRdata
);

  ctlStrobes_t       strobes;
  logic              hit, victimDirty, misaligned, isTagOp;
  logic [ADDR_W-1:0] victimLineAddr, reqLineAddr;

  token_line_cache_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .tokWe       (tokWe),
    .hit         (hit),
    .victimDirty (victimDirty),
    .misaligned  (misaligned),
    .isTagOp     (isTagOp),
    .memAck      (memAck),
    .reqReady    (reqReady),
    .memValid    (memValid),
    .memWrite    (memWrite),
    .strobes     (strobes)
  );

  token_line_cache_dp #(
    .ADDR_W     (ADDR_W),
    .LINES      (LINES),
    .LINE_BYTES (LINE_BYTES),
    .WORD_W     (WORD_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .reqOp          (reqOp),
    .reqAddr        (reqAddr),
    .reqWdata       (reqWdata),
    .tokData        (tokData),
    .memRdata       (memRdata),
    .hit            (hit),
    .victimDirty    (victimDirty),
    .misaligned     (misaligned),
    .isTagOp        (isTagOp),
    .victimLineAddr (victimLineAddr),
    .reqLineAddr    (reqLineAddr),
    .wbData         (memWdata),
    .rspValid       (rspValid),
    .rspData        (rspData),
    .rspViolation   (rspViolation),
    .rspError       (rspError)
  );

  assign memAddr = memWrite ? victimLineAddr : reqLineAddr;

endmodule

// File: rtl/token_line_cache_checker.sv
module token_line_cache_checker #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [WORD_W-1:0] rspData,
  input logic              rspViolation,
  input logic              rspError,
  input logic              memValid,
  input logic              memWrite,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr
);

  assert_viol_in_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspViolation |-> rspValid);

  assert_viol_zero_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspViolation |-> (rspData == '0));

  assert_viol_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspViolation |=> !rspViolation);

  assert_err_not_viol_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> !rspViolation);

  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memAck) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  assert_busy_during_mem_R12: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

endmodule

bind token_line_cache token_line_cache_checker #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W)
) chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqReady     (reqReady),
  .rspValid     (rspValid),
  .rspData      (rspData),
  .rspViolation (rspViolation),
  .rspError     (rspError),
  .memValid     (memValid),
  .memWrite     (memWrite),
  .memAck       (memAck),
  .memAddr      (memAddr)
);

// File: tb/token_line_cache_test.sv
`timescale 1ns/1ps
module token_line_cache_test;

  localparam int AW = 16;
  localparam int WW = 64;
  localparam int LW = 512;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqReady;
  logic [1:0] reqOp;
  logic [AW-1:0] reqAddr;
  logic [WW-1:0] reqWdata;
  logic rspValid, rspViolation, rspError;
  logic [WW-1:0] rspData;
  logic tokWe;
  logic [LW-1:0] tokData;
  logic memValid, memWrite, memAck;
  logic [AW-1:0] memAddr;
  logic [LW-1:0] memWdata, memRdata;

  always #2.5 clk = ~clk;

  token_line_cache uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .rspViolation(rspViolation),
    .rspError(rspError), .tokWe(tokWe), .tokData(tokData),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int writes = 0;
  bit done   = 1'b0;
  bit overlap = 1'b0;
  logic [AW-1:0] lastWrAddr;
  logic [LW-1:0] lastWrData;
  logic [LW-1:0] memStore [logic [AW-1:0]];
  logic [LW-1:0] tok1, tok2;
  logic postViol;

  function automatic logic [LW-1:0] patt(input logic [AW-1:0] a);
    logic [LW-1:0] r;
    for (int w = 0; w < 8; w++) r[w*64 +: 64] = {16'hA5A5, 16'(a >> 6), 32'(w)};
    return r;
  endfunction

  function automatic logic [LW-1:0] readLine(input logic [AW-1:0] a);
    if (memStore.exists(a)) return memStore[a];
    return patt(a);
  endfunction

  task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: acknowledges each transfer two cycles after it appears
  initial begin
    memAck = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memValid) begin
        repeat (2) @(negedge clk);
        if (memWrite) begin
          memStore[memAddr] = memWdata;
          lastWrAddr = memAddr;
          lastWrData = memWdata;
          writes++;
        end else begin
          memRdata = readLine(memAddr);
          reads++;
        end
        memAck = 1'b1;
      end
    end
  end

  always @(negedge clk) if (memValid && reqReady) overlap = 1'b1;

  task automatic doReq(input logic [1:0] op, input logic [AW-1:0] a, input logic [WW-1:0] wd,
                       input bit withTok, input logic [LW-1:0] newTok,
                       output logic [WW-1:0] d, output logic v, output logic e);
    reqOp = op; reqAddr = a; reqWdata = wd; reqValid = 1'b1;
    if (withTok) begin
      tokWe = 1'b1; tokData = newTok;
      #1;
      check("R11 reqReady low beside token write", LW'(reqReady), LW'(0));
      @(negedge clk);
      tokWe = 1'b0;
    end
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    d = rspData; v = rspViolation; e = rspError;
    @(negedge clk);
    postViol = rspViolation;
  endtask

  task automatic setTok(input logic [LW-1:0] t);
    tokWe = 1'b1; tokData = t;
    @(negedge clk);
    tokWe = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]    op;
    logic [15:0]   addr;
    logic [63:0]   wdata;
    logic [63:0]   expData;
    logic          expViol;
    logic          expErr;
    logic [3:0]    reqNo;
  } vec_t;

  // R2 R3 R4 R5 R6 R7 R9: sequential scenario on lines 0..3 and the token line
  localparam vec_t VECS [15] = '{
    '{2'd0, 16'h0008, 64'h0,                  64'hA5A5_0000_0000_0001, 1'b0, 1'b0, 4'd2},
    '{2'd1, 16'h0010, 64'h1111_2222_3333_4444, 64'h0,                  1'b0, 1'b0, 4'd4},
    '{2'd0, 16'h0010, 64'h0,                  64'h1111_2222_3333_4444, 1'b0, 1'b0, 4'd4},
    '{2'd0, 16'h1040, 64'h0,                  64'h0,                   1'b1, 1'b0, 4'd3},
    '{2'd1, 16'h1048, 64'hDEAD_DEAD_DEAD_DEAD, 64'h0,                  1'b1, 1'b0, 4'd6},
    '{2'd2, 16'h0083, 64'h0,                  64'h0,                   1'b0, 1'b1, 4'd9},
    '{2'd2, 16'h0080, 64'h0,                  64'h0,                   1'b0, 1'b0, 4'd5},
    '{2'd0, 16'h0088, 64'h0,                  64'h0,                   1'b1, 1'b0, 4'd5},
    '{2'd3, 16'h0081, 64'h0,                  64'h0,                   1'b0, 1'b1, 4'd9},
    '{2'd0, 16'h0090, 64'h0,                  64'h0,                   1'b1, 1'b0, 4'd9},
    '{2'd3, 16'h0080, 64'h0,                  64'h0,                   1'b0, 1'b0, 4'd7},
    '{2'd0, 16'h0098, 64'h0,                  64'h0,                   1'b0, 1'b0, 4'd7},
    '{2'd1, 16'h00C0, 64'h5555_6666_7777_8888, 64'h0,                  1'b0, 1'b0, 4'd4},
    '{2'd3, 16'h0040, 64'h0,                  64'h0,                   1'b0, 1'b0, 4'd7},
    '{2'd0, 16'h0048, 64'h0,                  64'hA5A5_0001_0000_0001, 1'b0, 1'b0, 4'd7}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] d;
    logic v, e;
    int wb, rb;
    logic [LW-1:0] line0Exp;
    for (int i = 0; i < 8; i++) begin
      tok1[i*64 +: 64] = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1);
      tok2[i*64 +: 64] = 64'hC2B2_AE3D_27D4_EB4F ^ 64'(i * 7 + 3);
    end
    memStore[16'h1040] = tok1;
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqAddr = '0; reqWdata = '0;
    tokWe = 1'b0; tokData = '0;
    repeat (3) @(negedge clk);
    check("R1 reqReady in reset", LW'(reqReady), LW'(1));
    check("R1 rspValid in reset", LW'(rspValid), LW'(0));
    check("R1 memValid in reset", LW'(memValid), LW'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 memValid after reset", LW'(memValid), LW'(0));
    setTok(tok1);

    for (int i = 0; i < 15; i++) begin
      doReq(VECS[i].op, VECS[i].addr, VECS[i].wdata, 1'b0, '0, d, v, e);
      check($sformatf("R%0d vec%0d data", VECS[i].reqNo, i), LW'(d), LW'(VECS[i].expData));
      check($sformatf("R%0d vec%0d violation", VECS[i].reqNo, i), LW'(v), LW'(VECS[i].expViol));
      check($sformatf("R%0d vec%0d error", VECS[i].reqNo, i), LW'(e), LW'(VECS[i].expErr));
      if (VECS[i].expViol)
        check($sformatf("R10 vec%0d violation pulse width", i), LW'(postViol), LW'(0));
    end

    // R8 and R6: dirty armed line evicted as token, blocked store not visible
    doReq(2'd2, 16'h0200, '0, 1'b0, '0, d, v, e);
    check("R5 arm line 8 no error", LW'(e), LW'(0));
    doReq(2'd1, 16'h0208, 64'hBAD0_BAD0_BAD0_BAD0, 1'b0, '0, d, v, e);
    check("R6 store to armed line violates", LW'(v), LW'(1));
    wb = writes;
    doReq(2'd0, 16'h2208, '0, 1'b0, '0, d, v, e);
    check("R2 load after eviction data", LW'(d), LW'(64'hA5A5_0088_0000_0001));
    check("R8 armed eviction writes once", LW'(writes), LW'(wb + 1));
    check("R8 armed eviction address", LW'(lastWrAddr), LW'(16'h0200));
    check("R8 R6 armed eviction writes token", lastWrData, tok1);
    doReq(2'd0, 16'h0208, '0, 1'b0, '0, d, v, e);
    check("R3 refill of written token violates", LW'(v), LW'(1));

    // R8: dirty plain line writes its data, clean line writes nothing
    line0Exp = patt(16'h0000);
    line0Exp[2*64 +: 64] = 64'h1111_2222_3333_4444;
    wb = writes;
    doReq(2'd0, 16'h0400, '0, 1'b0, '0, d, v, e);
    check("R2 load line 0x10 data", LW'(d), LW'(64'hA5A5_0010_0000_0000));
    check("R8 dirty eviction address", LW'(lastWrAddr), LW'(16'h0000));
    check("R8 R4 dirty eviction data", lastWrData, line0Exp);
    check("R8 dirty eviction count", LW'(writes), LW'(wb + 1));
    wb = writes; rb = reads;
    doReq(2'd0, 16'h0800, '0, 1'b0, '0, d, v, e);
    check("R8 clean eviction writes nothing", LW'(writes), LW'(wb));
    check("R2 miss reads once", LW'(reads), LW'(rb + 1));

    // R11: token write and load offered in the same cycle
    wb = writes; rb = reads;
    doReq(2'd0, 16'h00C0, '0, 1'b1, tok2, d, v, e);
    check("R11 dirty data dropped, memory word returned", LW'(d), LW'(64'hA5A5_0003_0000_0000));
    check("R11 no write-back after token write", LW'(writes), LW'(wb));
    check("R11 refetch after invalidation", LW'(reads), LW'(rb + 1));
    doReq(2'd0, 16'h1048, '0, 1'b0, '0, d, v, e);
    check("R11 old token line untagged under new token", LW'(v), LW'(0));
    check("R11 old token line data", LW'(d), LW'(tok1[64 +: 64]));

    check("R12 reqReady low during memory transfers", LW'(overlap), LW'(0));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule